// File: doc/BRIEF.md
# Interlocked Parallel-Bus Cycle Master

This block runs single read and write cycles on an asynchronous parallel backplane bus. All strobes on that bus are active low, and every cycle uses a full handshake. A local requester offers one transfer at a time with a valid/ready pair. The transfer carries a word address (bits 31..1), a 6-bit address modifier, a long-word flag, a data-strobe select, an address-width code, the direction and the write data. For each accepted request the block drives the address phase, raises the address strobe and then the data strobes. It waits for the slave to terminate the cycle and then returns one response pulse. The response carries a status code and, on reads, the captured data.

The termination inputs come from another clock domain, so each one passes through a synchronizer chain before any decision uses it. The block never asserts a data strobe while any termination line is still asserted from a previous cycle. It starts no new cycle until all three lines have been released. A pipelining enable lets the next request's address reach the bus as soon as the current cycle is terminated, while the slave may still be holding its acknowledge. Address widths that the cycle cannot carry are refused without touching the bus. A cycle with no termination is ended by a timeout.

Top module: `pbm_cycle_master`

## Requirements
- R1: After reset, address strobe, both data strobes, write line and interrupt-acknowledge are high (negated), the data drive enable is low, no response is pending and the request port is ready.
- R2: Address, modifier and long-word outputs (long-word pin low when the flag is set) are stable for at least one cycle before the address strobe falls. The address-width code selects the visible address bits: 0 drives only bits 15..1, 1 drives bits 23..1, 2 drives bits 31..1, and the remaining bits are driven 0.
- R3: Interrupt-acknowledge stays high at all times. The write line is low during a write and high during a read.
- R4: A data strobe falls only while the address strobe is low and only after the synchronized DTACK, BERR and RETRY have all been seen negated. A termination line that is still held low from earlier blocks the data strobes until it is released.
- R5: Strobe select bit 0 enables DS0 and bit 1 enables DS1. When both are selected, DS0 falls first and DS1 falls exactly one cycle later. A strobe that is not selected never falls.
- R6: The cycle ends on a synchronized termination. The status codes are 0 = OK (DTACK), 1 = bus error (BERR) and 2 = retry (RETRY). When several terminations are seen together, BERR outranks RETRY and RETRY outranks DTACK. The response is a one-cycle pulse issued with the address strobe and both data strobes already negated.
- R7: On a read, the response data equals the bus data present when the termination is recognized.
- R8: On a write, the data drive enable is high with the write data on the bus before the first data strobe falls, and it stays high while any data strobe is low.
- R9: With pipelining disabled, the bus address does not change and no new address strobe falls while any termination line is still low.
- R10: With pipelining enabled, a waiting request is accepted after termination and its address appears on the bus while DTACK is still held low. Its address strobe still waits for all terminations to be released.
- R11: Address-width codes 3 (40-bit) and 4 or above (64-bit and unused), and an all-zero strobe select, are refused with status 1 and no address strobe activity.
- R12: If no termination arrives within TIMEOUT_CYC cycles of the data strobes, the cycle ends with status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pipeEn | input | 1 | Allow the next address during the termination release |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqAddr | input | 31 | Word address bits 31..1 |
| reqAm | input | 6 | Address modifier |
| reqLong | input | 1 | Long-word flag |
| reqDs | input | 2 | Data-strobe select, bit 0 = DS0, bit 1 = DS1 |
| reqMode | input | 3 | Address-width code (0 = 16, 1 = 24, 2 = 32, 3 = 40, 4 = 64) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle response pulse |
| rspStatus | output | 2 | 0 OK, 1 bus error, 2 retry |
| rspRdata | output | 32 | Read data |
| busAddr | output | 31 | Address lines A31..A1 |
| busAm | output | 6 | Address modifier lines |
| busLwordN | output | 1 | Long-word line, active low |
| busIackN | output | 1 | Interrupt acknowledge, held high |
| busAsN | output | 1 | Address strobe, active low |
| busDs0N | output | 1 | Data strobe 0, active low |
| busDs1N | output | 1 | Data strobe 1, active low |
| busWriteN | output | 1 | Write line, low for write |
| busDataOut | output | 32 | Data driven on writes |
| busDataOe | output | 1 | Data drive enable |
| busDataIn | input | 32 | Data bus as seen by the master |
| busDtackN | input | 1 | Data acknowledge, active low |
| busBerrN | input | 1 | Bus error, active low |
| busRetryN | input | 1 | Retry, active low |

## Verification
The bench builds the block with TIMEOUT_CYC = 40 and the default two synchronizer stages. The short timeout lets the silent-slave case and its bus-error status finish within a few dozen cycles. The two-stage chain keeps every handshake latency to a small, known number of cycles. With these values, a slave model with adjustable response delay and release hold can hold DTACK low long enough to separate pipelined from non-pipelined address timing. A stuck termination line shows that the data strobes stay high until the line is released.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_BERR  = 2'd1,
    RSP_RETRY = 2'd2
  } rspCodeT;

  typedef enum logic [2:0] {
    AMODE_16 = 3'd0,
    AMODE_24 = 3'd1,
    AMODE_32 = 3'd2,
    AMODE_40 = 3'd3,
    AMODE_64 = 3'd4
  } addrModeT;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // take a new request into the address/data registers
    logic capture;  // latch read data at termination
    logic tmoRun;   // timeout counter enabled
  } ctlStrobeT;

  function automatic logic reqAcceptable(input logic [2:0] mode, input logic [1:0] dsSel);
    return (mode <= AMODE_32) && (dsSel != 2'b00);
  endfunction
endpackage

// File: rtl/pbm_sync.sv
module pbm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '1;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '1;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pbm_datapath.sv
module pbm_datapath
  import pbm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int AM_W        = 6,
  parameter int TIMEOUT_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:1] reqAddr,
  input  logic [AM_W-1:0]   reqAm,
  input  logic              reqLong,
  input  logic [2:0]        reqMode,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busDtackN,
  input  logic              busBerrN,
  input  logic              busRetryN,
  output logic [ADDR_W-2:0] busAddr,
  output logic [AM_W-1:0]   busAm,
  output logic              busLwordN,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rspRdata,
  output logic              termsClear,
  output logic              dtackSeen,
  output logic              berrSeen,
  output logic              retrySeen,
  output logic              tmoHit,
  output logic              wrLatched
);
  localparam int AW1   = ADDR_W - 1;
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [AW1-1:0] MASK_ALL = '1;
  localparam logic [AW1-1:0] MASK_16  = MASK_ALL >> (ADDR_W - 16);
  localparam logic [AW1-1:0] MASK_24  = MASK_ALL >> (ADDR_W - 24);

  logic [AW1-1:0]    addrReg;
  logic [AM_W-1:0]   amReg;
  logic              lwReg;
  logic              wrReg;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdReg;
  logic [2:0]        termSync;
  logic [TMO_W-1:0]  tmoCnt;
  logic [AW1-1:0]    modeMask;

  always_comb begin
    case (reqMode)
      AMODE_16: modeMask = MASK_16;
      AMODE_24: modeMask = MASK_24;
      default:  modeMask = MASK_ALL;
    endcase
  end

  // Request registers: the address phase is held here for the whole cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      amReg   <= '0;
      lwReg   <= 1'b0;
      wrReg   <= 1'b0;
      wdReg   <= '0;
    end else if (ctl.load) begin
      addrReg <= reqAddr & modeMask;
      amReg   <= reqAm;
      lwReg   <= reqLong;
      wrReg   <= reqWrite;
      wdReg   <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdReg <= '0;
    else if (ctl.capture) rdReg <= busDataIn;
  end

  pbm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_termSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({busRetryN, busBerrN, busDtackN}),
    .dout (termSync)
  );

  assign dtackSeen  = !termSync[0];
  assign berrSeen   = !termSync[1];
  assign retrySeen  = !termSync[2];
  assign termsClear = &termSync;

  // Timeout counter, cleared whenever the sequencer is not waiting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmoCnt <= '0;
    else if (!ctl.tmoRun) tmoCnt <= '0;
    else if (!tmoHit)     tmoCnt <= tmoCnt + 1'b1;
  end
  assign tmoHit = (tmoCnt == TMO_W'(TIMEOUT_CYC - 1));

  assign busAddr    = addrReg;
  assign busAm      = amReg;
  assign busLwordN  = !lwReg;
  assign busWriteN  = !wrReg;
  assign busDataOut = wdReg;
  assign rspRdata   = rdReg;
  assign wrLatched  = wrReg;

  AST_TMO_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    tmoHit |-> $past(ctl.tmoRun)); // R12
endmodule

// File: rtl/pbm_control.sv
module pbm_control
  import pbm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeEn,
  input  logic       reqValid,
  input  logic [1:0] reqDs,
  input  logic [2:0] reqMode,
  input  logic       termsClear,
  input  logic       dtackSeen,
  input  logic       berrSeen,
  input  logic       retrySeen,
  input  logic       tmoHit,
  input  logic       wrLatched,
  output logic       reqReady,
  output ctlStrobeT  ctl,
  output logic       asN,
  output logic       ds0N,
  output logic       ds1N,
  output logic       dataOe,
  output logic       rspValid,
  output logic [1:0] rspStatus
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_GATE, ST_DSB, ST_WAIT, ST_REL
  } stateT;

  stateT      state;
  logic [1:0] dsSel;
  logic       pendNext;
  logic       accept;
  logic       reqOk;
  logic       termAny;
  rspCodeT    termCode;

  assign reqReady = (state == ST_IDLE) || (state == ST_REL && pipeEn && !pendNext);
  assign accept   = reqValid && reqReady;
  assign reqOk    = reqAcceptable(reqMode, reqDs);
  assign termAny  = dtackSeen || berrSeen || retrySeen;

  always_comb begin
    if (berrSeen || (tmoHit && !termAny)) termCode = RSP_BERR;
    else if (retrySeen)                   termCode = RSP_RETRY;
    else                                  termCode = RSP_OK;
  end

  always_comb begin
    ctl.load    = accept && reqOk;
    ctl.capture = (state == ST_WAIT) && termAny;
    ctl.tmoRun  = (state == ST_WAIT);
  end

  assign dataOe = wrLatched && (state == ST_SETUP || state == ST_GATE ||
                                state == ST_DSB || state == ST_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dsSel     <= 2'b00;
      pendNext  <= 1'b0;
      asN       <= 1'b1;
      ds0N      <= 1'b1;
      ds1N      <= 1'b1;
      rspValid  <= 1'b0;
      rspStatus <= RSP_OK;
    end else begin
      rspValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reqOk) begin
              dsSel <= reqDs;
              state <= ST_SETUP;
            end else begin
              rspValid  <= 1'b1;
              rspStatus <= RSP_BERR;
            end
          end
        end
        ST_SETUP: begin
          asN   <= 1'b0;
          state <= ST_GATE;
        end
        ST_GATE: begin
          if (termsClear) begin
            if (dsSel[0]) ds0N <= 1'b0;
            else          ds1N <= 1'b0;
            state <= (dsSel == 2'b11) ? ST_DSB : ST_WAIT;
          end
        end
        ST_DSB: begin
          ds1N  <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (termAny || tmoHit) begin
            asN       <= 1'b1;
            ds0N      <= 1'b1;
            ds1N      <= 1'b1;
            rspValid  <= 1'b1;
            rspStatus <= termCode;
            state     <= ST_REL;
          end
        end
        ST_REL: begin
          if (accept) begin
            if (reqOk) begin
              dsSel    <= reqDs;
              pendNext <= 1'b1;
            end else begin
              rspValid  <= 1'b1;
              rspStatus <= RSP_BERR;
            end
          end
          if (termsClear) begin
            pendNext <= 1'b0;
            state    <= (pendNext || (accept && reqOk)) ? ST_SETUP : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DS_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ds0N) || ($fell(ds1N) && ds0N)) |-> $past(termsClear)); // R4
  AST_DS_UNDER_AS: assert property (@(posedge clk) disable iff (!rstN)
    (!ds0N || !ds1N) |-> !asN); // R4
  AST_DS1_FOLLOWS_DS0: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ds1N) && !ds0N) |-> $past(!ds0N)); // R5
  AST_RSP_STROBES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (asN && ds0N && ds1N)); // R6
  AST_WRITE_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    ((!ds0N || !ds1N) && wrLatched) |-> dataOe); // R8
endmodule

// File: rtl/pbm_cycle_master.sv
module pbm_cycle_master
  import pbm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int AM_W        = 6,
  parameter int TIMEOUT_CYC = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:1] reqAddr,
  input  logic [AM_W-1:0]   reqAm,
  input  logic              reqLong,
  input  logic [1:0]        reqDs,
  input  logic [2:0]        reqMode,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-2:0] busAddr,
  output logic [AM_W-1:0]   busAm,
  output logic              busLwordN,
  output logic              busIackN,
  output logic              busAsN,
  output logic              busDs0N,
  output logic              busDs1N,
  output logic              busWriteN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busDtackN,
  input  logic              busBerrN,
  input  logic              busRetryN
);
  ctlStrobeT ctl;
  logic termsClear, dtackSeen, berrSeen, retrySeen, tmoHit, wrLatched;

  assign busIackN = 1'b1;

  pbm_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pipeEn     (pipeEn),
    .reqValid   (reqValid),
    .reqDs      (reqDs),
    .reqMode    (reqMode),
    .termsClear (termsClear),
    .dtackSeen  (dtackSeen),
    .berrSeen   (berrSeen),
    .retrySeen  (retrySeen),
    .tmoHit     (tmoHit),
    .wrLatched  (wrLatched),
    .reqReady   (reqReady),
    .ctl        (ctl),
    .asN        (busAsN),
    .ds0N       (busDs0N),
    .ds1N       (busDs1N),
    .dataOe     (busDataOe),
    .rspValid   (rspValid),
    .rspStatus  (rspStatus)
  );

  pbm_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AM_W(AM_W),
    .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqAm      (reqAm),
    .reqLong    (reqLong),
    .reqMode    (reqMode),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .busDtackN  (busDtackN),
    .busBerrN   (busBerrN),
    .busRetryN  (busRetryN),
    .busAddr    (busAddr),
    .busAm      (busAm),
    .busLwordN  (busLwordN),
    .busWriteN  (busWriteN),
    .busDataOut (busDataOut),
    .rspRdata   (rspRdata),
    .termsClear (termsClear),
    .dtackSeen  (dtackSeen),
    .berrSeen   (berrSeen),
    .retrySeen  (retrySeen),
    .tmoHit     (tmoHit),
    .wrLatched  (wrLatched)
  );
endmodule

// File: tb/sim_pbm_cycle_master.sv
module sim_pbm_cycle_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        pipeEn = 1'b0, reqValid = 1'b0, reqReady;
  logic [31:1] reqAddr = '0;
  logic [5:0]  reqAm = '0;
  logic        reqLong = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqDs = 2'b00;
  logic [2:0]  reqMode = 3'd0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [31:0] rspRdata;
  logic [30:0] busAddr;
  logic [5:0]  busAm;
  logic        busLwordN, busIackN, busAsN, busDs0N, busDs1N, busWriteN, busDataOe;
  logic [31:0] busDataOut, busDataIn;
  logic        slvDtackN = 1'b1, slvBerrN = 1'b1, slvRetryN = 1'b1, stuck = 1'b0;
  logic        busDtackN, busBerrN, busRetryN;
  logic [31:0] slvRdata = '0, slvData = '0;
  logic [2:0]  slvMask = 3'b001;  // {retry, berr, dtack}
  int          slvDelay = 2, slvHold = 1;

  assign busDtackN = slvDtackN & ~stuck;
  assign busBerrN  = slvBerrN;
  assign busRetryN = slvRetryN;
  assign busDataIn = slvData;

  pbm_cycle_master #(.TIMEOUT_CYC(40)) u0 (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqAm(reqAm), .reqLong(reqLong), .reqDs(reqDs), .reqMode(reqMode),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .rspValid(rspValid), .rspStatus(rspStatus),
    .rspRdata(rspRdata), .busAddr(busAddr), .busAm(busAm), .busLwordN(busLwordN),
    .busIackN(busIackN), .busAsN(busAsN), .busDs0N(busDs0N), .busDs1N(busDs1N),
    .busWriteN(busWriteN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busDtackN(busDtackN), .busBerrN(busBerrN), .busRetryN(busRetryN)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave model: answers any data strobe after slvDelay, holds until strobes drop plus slvHold
  initial begin
    forever begin
      @(negedge clk);
      if (!busDs0N || !busDs1N) begin
        repeat (slvDelay) @(negedge clk);
        slvData   = slvRdata;
        slvDtackN = ~slvMask[0];
        slvBerrN  = ~slvMask[1];
        slvRetryN = ~slvMask[2];
        while (!(busDs0N && busDs1N)) @(negedge clk);
        repeat (slvHold) @(negedge clk);
        slvDtackN = 1'b1;
        slvBerrN  = 1'b1;
        slvRetryN = 1'b1;
      end
    end
  end

  // Bus monitor
  int cyc = 0, asFalls = 0, ds0Falls = 0, ds1Falls = 0, ds0Cyc = 0, ds1Cyc = 0;
  int addrSetupBad = 0, interlockBad = 0, oeBad = 0, iackBad = 0, pipeSeen = 0, asTermBad = 0;
  logic [30:0] asAddr, prevAddr = '0;
  logic [5:0]  asAm;
  logic        asLw, wrLineAtDs = 1'b1, prevAs = 1'b1, prevDs0 = 1'b1, prevDs1 = 1'b1;
  logic [31:0] wdataSeen = '0;
  logic        anyTermLow;
  assign anyTermLow = !busDtackN || !busBerrN || !busRetryN;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevAs && !busAsN) begin
        asFalls++;
        asAddr = busAddr; asAm = busAm; asLw = busLwordN;
        if (busAddr !== prevAddr) addrSetupBad++;
        if (anyTermLow) asTermBad++;
      end
      if ((prevDs0 && !busDs0N) || (prevDs1 && !busDs1N)) begin
        if (anyTermLow || busAsN) interlockBad++;
        wrLineAtDs = busWriteN;
        if (!busWriteN) begin
          wdataSeen = busDataOut;
          if (!busDataOe) oeBad++;
        end
      end
      if (prevDs0 && !busDs0N) begin ds0Falls++; ds0Cyc = cyc; end
      if (prevDs1 && !busDs1N) begin ds1Falls++; ds1Cyc = cyc; end
      if ((!busDs0N || !busDs1N) && !busWriteN && !busDataOe) oeBad++;
      if (!busIackN) iackBad++;
      if (busAddr !== prevAddr && !busDtackN) pipeSeen++;
      prevAs = busAsN; prevDs0 = busDs0N; prevDs1 = busDs1N; prevAddr = busAddr;
    end
  end

  int rspCnt = 0;
  logic [1:0]  rspStat [64];
  logic [31:0] rspData [64];
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspStat[rspCnt % 64] = rspStatus;
      rspData[rspCnt % 64] = rspRdata;
      rspCnt++;
    end
  end

  task automatic clearMon();
    asFalls = 0; ds0Falls = 0; ds1Falls = 0; addrSetupBad = 0; interlockBad = 0;
    oeBad = 0; iackBad = 0; pipeSeen = 0; asTermBad = 0;
  endtask

  task automatic setSlave(input logic [2:0] mask, input int dly, input int hold, input logic [31:0] rd);
    slvMask = mask; slvDelay = dly; slvHold = hold; slvRdata = rd;
  endtask

  task automatic issue(input logic [31:1] a, input logic [5:0] am, input logic lng,
                       input logic [1:0] ds, input logic [2:0] mode, input logic wr,
                       input logic [31:0] wd);
    @(negedge clk);
    reqAddr = a; reqAm = am; reqLong = lng; reqDs = ds; reqMode = mode;
    reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(input int n);
    for (int i = 0; i < 400 && rspCnt < n; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 asN", busAsN, 1); chk("R1 ds0N", busDs0N, 1); chk("R1 ds1N", busDs1N, 1);
    chk("R1 writeN", busWriteN, 1); chk("R1 iackN", busIackN, 1);
    chk("R1 oe", busDataOe, 0); chk("R1 rspValid", rspValid, 0); chk("R1 ready", reqReady, 1);
  endtask

  task automatic t_read32();
    int n = rspCnt;
    clearMon(); setSlave(3'b001, 2, 1, 32'hCAFEF00D);
    issue(31'h6F56F770, 6'h0D, 1'b1, 2'b11, 3'd2, 1'b0, '0);
    waitRsp(n + 1);
    chk("R6 read OK status", rspStat[n % 64], 0);
    chk("R7 read data", rspData[n % 64], 32'hCAFEF00D);
    chk("R2 addr 32-bit", asAddr, 31'h6F56F770);
    chk("R2 am", asAm, 6'h0D); chk("R2 lword low", asLw, 0);
    chk("R2 addr setup", addrSetupBad, 0);
    chk("R5 ds1 one cycle after ds0", ds1Cyc - ds0Cyc, 1);
    chk("R3 write line high on read", wrLineAtDs, 1);
    chk("R3 iack never low", iackBad, 0);
    chk("R4 interlock", interlockBad, 0);
  endtask

  task automatic t_write16();
    int n = rspCnt;
    clearMon(); setSlave(3'b001, 3, 0, '0);
    issue(31'h091A2B3C, 6'h29, 1'b0, 2'b01, 3'd0, 1'b1, 32'h11223344);
    waitRsp(n + 1);
    chk("R6 write OK", rspStat[n % 64], 0);
    chk("R2 addr 16-bit mask", asAddr, 31'h2B3C);
    chk("R2 lword high", asLw, 1);
    chk("R3 write line low", wrLineAtDs, 0);
    chk("R8 write data", wdataSeen, 32'h11223344);
    chk("R8 oe held", oeBad, 0);
    chk("R5 ds1 unused", ds1Falls, 0);
  endtask

  task automatic t_ds1only24();
    int n = rspCnt;
    clearMon(); setSlave(3'b001, 1, 0, 32'h0000BEEF);
    issue(31'h7ABCDEF1, 6'h39, 1'b0, 2'b10, 3'd1, 1'b0, '0);
    waitRsp(n + 1);
    chk("R5 ds0 unused", ds0Falls, 0); chk("R5 ds1 used", ds1Falls, 1);
    chk("R2 addr 24-bit mask", asAddr, 31'h3CDEF1);
    chk("R7 read data", rspData[n % 64], 32'h0000BEEF);
  endtask

  task automatic t_term(input logic [2:0] mask, input logic [1:0] exp, input string tag);
    int n = rspCnt;
    clearMon(); setSlave(mask, 2, 1, '0);
    issue(31'h100, 6'h09, 1'b0, 2'b11, 3'd2, 1'b0, '0);
    waitRsp(n + 1);
    chk(tag, rspStat[n % 64], exp);
  endtask

  task automatic t_timeout();
    int n = rspCnt;
    clearMon(); setSlave(3'b000, 2, 0, '0);
    issue(31'h200, 6'h09, 1'b0, 2'b01, 3'd2, 1'b0, '0);
    waitRsp(n + 1);
    chk("R12 timeout berr", rspStat[n % 64], 1);
    chk("R12 one response", rspCnt, n + 1);
  endtask

  task automatic t_reject(input logic [2:0] mode, input logic [1:0] ds, input string tag);
    int n = rspCnt;
    clearMon(); setSlave(3'b001, 2, 0, '0);
    issue(31'h300, 6'h09, 1'b0, ds, mode, 1'b0, '0);
    waitRsp(n + 1);
    chk(tag, rspStat[n % 64], 1);
    chk("R11 no address strobe", asFalls, 0);
  endtask

  task automatic t_stuck();
    int n = rspCnt;
    clearMon(); setSlave(3'b001, 2, 0, 32'h5A5A0001);
    stuck = 1'b1;
    issue(31'h400, 6'h09, 1'b0, 2'b01, 3'd2, 1'b0, '0);
    repeat (12) @(negedge clk);
    chk("R4 strobes held while stale dtack", ds0Falls, 0);
    stuck = 1'b0;
    waitRsp(n + 1);
    chk("R4 completes after release", rspStat[n % 64], 0);
    chk("R4 interlock", interlockBad, 0);
  endtask

  task automatic t_pair(input logic pe, input string tag);
    int n = rspCnt;
    clearMon(); pipeEn = pe; setSlave(3'b001, 2, 6, 32'h77);
    issue(31'h0AAA, 6'h09, 1'b0, 2'b11, 3'd2, 1'b0, '0);
    issue(31'h0BBB, 6'h09, 1'b0, 2'b11, 3'd2, 1'b0, '0);
    waitRsp(n + 2);
    chk({tag, " both ok"}, {rspStat[n % 64], rspStat[(n + 1) % 64]}, 0);
    chk({tag, " second addr"}, asAddr, 31'h0BBB);
    chk({tag, " no AS during termination"}, asTermBad, 0);
    if (pe) chk("R10 early address", pipeSeen > 0, 1);
    else    chk("R9 address held", pipeSeen, 0);
    pipeEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_read32();
    t_write16();
    t_ds1only24();
    t_term(3'b010, 2'd1, "R6 berr");
    t_term(3'b100, 2'd2, "R6 retry");
    t_term(3'b110, 2'd1, "R6 berr over retry");
    t_term(3'b101, 2'd2, "R6 retry over dtack");
    t_timeout();
    t_reject(3'd3, 2'b11, "R11 40-bit refused");
    t_reject(3'd4, 2'b11, "R11 64-bit refused");
    t_reject(3'd2, 2'b00, "R11 empty strobe select");
    t_stuck();
    t_pair(1'b0, "R9");
    t_pair(1'b1, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule